// File: doc/BRIEF.md
# DRAM Out-of-Page Cycle Sequencer

This block drives one complete out-of-page cycle on a DRAM with separate row and column strobes: a read, a write, or a refresh in which the column strobe falls before the row strobe. It is clocked by a quarter-cycle timebase, four ticks per processor clock, so each pin edge can sit on a quarter-clock boundary. A frame lasts 4·(N+1) ticks for a wait-state setting N. The default of fifteen gives a 64-tick frame, and in that frame every edge falls on a fixed tick.

The host pulses an access request, with a write select, row, column and write data, or it pulses a refresh request. A request that arrives during a frame waits until that frame ends. The next frame then begins on the following tick, and a pending refresh goes ahead of a pending access. Every DRAM-side pin is driven from a register. For settings other than fifteen, each edge position is scaled as ⌊k·(N+1)/16⌋ of its 64-tick position k, so the order of the edges is kept.

Top module: `dram_oop_seq`

## Requirements
- R1: While reset is held, ras_n, cas_n, we_n and oe_rd_n are 1, and dq_oe and done are 0.
- R2: Frames run back to back, so at N=15 one row-strobe fall comes exactly 64 ticks after the previous one. Phase p counts ticks from the first tick of a frame's pins.
- R3: ras_n is low for phases 25 to 63 at N=15, which is 39 ticks low and 25 ticks of precharge.
- R4: On an access, cas_n is low for phases 39 to 57. dram_addr carries the row for phases 0 to 35 and the column from phase 36.
- R5: On a read, oe_rd_n is low for phases 1 to 62. rdata takes the value of dq_in at the tick where cas_n rises (phase 58).
- R6: On a write, we_n is low for phases 1 to 62, dq_oe is 1 for phases 4 to 63, and dq_out holds the write data.
- R7: On a refresh, cas_n is low for phases 19 to 57 and ras_n for phases 25 to 63. we_n, oe_rd_n and dq_oe stay inactive.
- R8: A request made during a frame is held. Its frame starts at the tick right after the current frame's last phase.
- R9: When a refresh and an access are both pending, the refresh frame runs first.
- R10: done is 1 for the last four phases of every frame.
- R11: The wait-state input is sampled when a frame starts, and values below 3 are treated as 3. Every edge phase k of the 64-tick frame becomes ⌊k·(N+1)/16⌋.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-cycle tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_cfg | input | WSW | Wait-state setting N |
| acc_req | input | 1 | One-tick access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| row | input | AW | Row address |
| col | input | AW | Column address |
| wdata | input | DW | Write data |
| ref_req | input | 1 | One-tick refresh request |
| rdata | output | DW | Read data |
| done | output | 1 | End-of-frame strobe |
| dram_addr | output | AW | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_rd_n | output | 1 | Read-enable strobe, active low |
| dq_out | output | DW | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | DW | Data bus input value |

## Verification
The assertions assume that requests are pulses lasting one tick and are never raised while reset is held. They also assume that the wait-state input only matters at frame start. The bench keeps to this by pulsing each request for exactly one tick, changing the wait setting only once the sequencer and its pending flags are idle, and releasing reset before any stimulus. dq_in changes on every tick, so a read sampled on the wrong tick yields a visibly different value.

// File: rtl/dram_oop_seq.sv
module dram_oop_seq #(
  parameter int AW  = 12,
  parameter int DW  = 24,
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WSW-1:0] wait_cfg,
  input  logic           acc_req,
  input  logic           acc_we,
  input  logic [AW-1:0]  row,
  input  logic [AW-1:0]  col,
  input  logic [DW-1:0]  wdata,
  input  logic           ref_req,
  output logic [DW-1:0]  rdata,
  output logic           done,
  output logic [AW-1:0]  dram_addr,
  output logic           ras_n,
  output logic           cas_n,
  output logic           we_n,
  output logic           oe_rd_n,
  output logic [DW-1:0]  dq_out,
  output logic           dq_oe,
  input  logic [DW-1:0]  dq_in
);
  localparam int CW = WSW + 3;
  localparam logic [WSW-1:0] WS_MIN = WSW'(3);

  typedef enum logic [1:0] {OP_RD, OP_WR, OP_REF} op_t;

  // edge positions are given on the 64-tick frame and scaled by (N+1)/16
  function automatic logic [CW-1:0] at(input int k, input logic [WSW-1:0] w);
    return CW'((k * (int'(w) + 1)) >> 4);
  endfunction

  logic           active, pend_ref, pend_acc, h_we;
  logic [CW-1:0]  cnt;
  logic [WSW-1:0] wl;
  op_t            op;
  logic [AW-1:0]  h_row, h_col, f_row, f_col;
  logic [DW-1:0]  h_wd, f_wd;

  wire [CW-1:0] f_len  = at(64, wl);
  wire          last   = active && (cnt == f_len - CW'(1));
  wire          launch = (!active || last) && (pend_ref || pend_acc);
  wire          is_wr  = active && op == OP_WR;
  wire          is_rd  = active && op == OP_RD;
  wire          is_ref = active && op == OP_REF;
  wire [CW-1:0] cas_on = is_ref ? at(19, wl) : at(39, wl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; cnt <= '0; wl <= WS_MIN; op <= OP_RD;
      pend_ref <= 1'b0; pend_acc <= 1'b0; h_we <= 1'b0;
      h_row <= '0; h_col <= '0; h_wd <= '0;
      f_row <= '0; f_col <= '0; f_wd <= '0;
      ras_n <= 1'b1; cas_n <= 1'b1; we_n <= 1'b1; oe_rd_n <= 1'b1;
      dq_oe <= 1'b0; done <= 1'b0; dram_addr <= '0; dq_out <= '0; rdata <= '0;
    end else begin
      pend_ref <= (pend_ref && !launch) || ref_req;
      pend_acc <= (pend_acc && !(launch && !pend_ref)) || acc_req;
      if (acc_req) begin
        h_we <= acc_we; h_row <= row; h_col <= col; h_wd <= wdata;
      end
      if (launch) begin
        active <= 1'b1;
        cnt    <= '0;
        wl     <= (wait_cfg < WS_MIN) ? WS_MIN : wait_cfg;
        op     <= pend_ref ? OP_REF : (h_we ? OP_WR : OP_RD);
        f_row  <= h_row; f_col <= h_col; f_wd <= h_wd;
      end else if (last) begin
        active <= 1'b0;
      end else if (active) begin
        cnt <= cnt + CW'(1);
      end

      ras_n   <= !(active && cnt >= at(25, wl));
      cas_n   <= !(active && cnt >= cas_on && cnt < at(58, wl));
      we_n    <= !(is_wr && cnt >= at(1, wl) && cnt < at(63, wl));
      oe_rd_n <= !(is_rd && cnt >= at(1, wl) && cnt < at(63, wl));
      dq_oe   <= is_wr && cnt >= at(4, wl);
      done    <= active && cnt >= f_len - CW'(4);
      if (active) dram_addr <= (cnt >= at(36, wl)) ? f_col : f_row;
      if (is_wr) dq_out <= f_wd;
      if (is_rd && cnt == at(58, wl)) rdata <= dq_in;
    end
  end

  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_rd_n));
  a_r3_cas_idle_at_ras_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);
  a_r4_access_ras_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !we_n |-> !ras_n);
  a_r7_refresh_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && we_n && oe_rd_n |-> ras_n);
  a_r6_bus_under_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n || $past(!we_n));
  a_r10_done_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !ras_n);
endmodule

// File: tb/dram_oop_seq_tb.sv
module dram_oop_seq_tb;
  localparam int AW = 12, DW = 24, WSW = 4;

  logic clk = 0, rst_n = 0;
  logic [WSW-1:0] wait_cfg = 4'd15;
  logic acc_req = 0, acc_we = 0, ref_req = 0;
  logic [AW-1:0] row = 0, col = 0;
  logic [DW-1:0] wdata = 0, dq_in = 0;
  logic [DW-1:0] rdata, dq_out;
  logic [AW-1:0] dram_addr;
  logic done, ras_n, cas_n, we_n, oe_rd_n, dq_oe;

  always #2.5 clk = ~clk;

  dram_oop_seq #(.AW(AW), .DW(DW), .WSW(WSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wait_cfg(wait_cfg), .acc_req(acc_req), .acc_we(acc_we),
    .row(row), .col(col), .wdata(wdata), .ref_req(ref_req), .rdata(rdata), .done(done),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_rd_n(oe_rd_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase of the frame being driven onto the pins
  int m_ph = -1, m_w = 15, m_F = 64, m_op = 0;  // op 0 read, 1 write, 2 refresh
  bit m_pr = 0, m_pa = 0, m_hwe = 0;
  int m_hrow = 0, m_hcol = 0, m_hwd = 0, m_row = 0, m_col = 0, m_wd = 0;
  bit e_ras = 1, e_cas = 1, e_we = 1, e_rd = 1, e_oe = 0, e_done = 0;
  int e_addr = 0, e_dq = 0, e_rdata = 0;

  function automatic int off(input int k, input int w);
    return (k * (w + 1)) / 16;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = -1; m_pr = 0; m_pa = 0; m_w = 3;
      e_ras = 1; e_cas = 1; e_we = 1; e_rd = 1; e_oe = 0; e_done = 0;
      e_addr = 0; e_dq = 0; e_rdata = 0;
    end else begin
      if (m_ph >= 0) begin
        int p; p = m_ph;
        e_ras  = !(p >= off(25, m_w));
        e_cas  = !(p >= off(m_op == 2 ? 19 : 39, m_w) && p < off(58, m_w));
        e_we   = !(m_op == 1 && p >= off(1, m_w) && p < off(63, m_w));
        e_rd   = !(m_op == 0 && p >= off(1, m_w) && p < off(63, m_w));
        e_oe   = (m_op == 1 && p >= off(4, m_w));
        e_done = (p >= m_F - 4);
        e_addr = (p >= off(36, m_w)) ? m_col : m_row;
        if (m_op == 1) e_dq = m_wd;
        if (m_op == 0 && p == off(58, m_w)) e_rdata = int'(dq_in);
      end else begin
        e_ras = 1; e_cas = 1; e_we = 1; e_rd = 1; e_oe = 0; e_done = 0;
      end
      if ((m_ph < 0 || m_ph == m_F - 1) && (m_pr || m_pa)) begin
        m_ph = 0;
        m_w = (int'(wait_cfg) < 3) ? 3 : int'(wait_cfg);
        m_F = 4 * (m_w + 1);
        m_op = m_pr ? 2 : (m_hwe ? 1 : 0);
        m_row = m_hrow; m_col = m_hcol; m_wd = m_hwd;
        if (m_pr) m_pr = 0; else m_pa = 0;
      end else if (m_ph >= 0 && m_ph < m_F - 1) m_ph++;
      else m_ph = -1;
      if (ref_req) m_pr = 1;
      if (acc_req) begin
        m_pa = 1; m_hwe = acc_we; m_hrow = int'(row); m_hcol = int'(col); m_hwd = int'(wdata);
      end
    end
  end

  int tick = 0;
  int rf[$], rr[$], cf[$];
  bit p_ras = 1, p_cas = 1;

  always @(negedge clk) begin
    tick++;
    dq_in <= DW'(tick * 7 + 3);
    if (rst_n) begin
      chk(ras_n == e_ras, "R3 ras_n", ras_n, e_ras);
      chk(cas_n == e_cas, "R4/R7 cas_n", cas_n, e_cas);
      chk(we_n == e_we, "R6 we_n", we_n, e_we);
      chk(oe_rd_n == e_rd, "R5 oe_rd_n", oe_rd_n, e_rd);
      chk(dq_oe == e_oe, "R6 dq_oe", dq_oe, e_oe);
      chk(done == e_done, "R10 done", done, e_done);
      chk(int'(dram_addr) == e_addr, "R4 dram_addr", dram_addr, e_addr);
      chk(int'(dq_out) == e_dq, "R6 dq_out", dq_out, e_dq);
      chk(int'(rdata) == e_rdata, "R5 rdata", rdata, e_rdata);
      if (p_ras && !ras_n) rf.push_back(tick);
      if (!p_ras && ras_n) rr.push_back(tick);
      if (p_cas && !cas_n) cf.push_back(tick);
    end
    p_ras = ras_n; p_cas = cas_n;
  end

  task automatic access(input bit we, input int r, input int c, input int d);
    @(negedge clk);
    acc_req = 1; acc_we = we; row = AW'(r); col = AW'(c); wdata = DW'(d);
    @(negedge clk);
    acc_req = 0;
  endtask

  task automatic refresh();
    @(negedge clk); ref_req = 1;
    @(negedge clk); ref_req = 0;
  endtask

  task automatic idle();
    repeat (3) @(negedge clk);
    while (m_ph >= 0 || m_pr || m_pa) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_log();
    rf.delete(); rr.delete(); cf.delete();
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_rd_n && !dq_oe && !done, "R1 reset state",
        {ras_n, cas_n, we_n, oe_rd_n, dq_oe, done}, 6'b111100);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R8: write, then a read queued mid-frame runs back to back
    clear_log();
    access(1, 12'h3A5, 12'h05C, 24'hA5C3F0);
    repeat (20) @(negedge clk);
    access(0, 12'h111, 12'h222, 0);
    idle();
    chk(rf.size() == 2, "R8 queued frame count", rf.size(), 2);
    if (rf.size() == 2) chk(rf[1] - rf[0] == 64, "R2 ras to ras", rf[1] - rf[0], 64);
    if (rr.size() >= 1) chk(rr[0] - rf[0] == 39, "R3 ras low width", rr[0] - rf[0], 39);

    // R9: both requested on the same tick, refresh goes first
    clear_log();
    @(negedge clk);
    ref_req = 1; acc_req = 1; acc_we = 0; row = 12'h0F0; col = 12'h00F;
    @(negedge clk);
    ref_req = 0; acc_req = 0;
    idle();
    chk(cf.size() == 2 && rf.size() == 2, "R9 two frames", cf.size(), 2);
    if (cf.size() == 2 && rf.size() == 2)
      chk(cf[0] < rf[0], "R9 refresh first (cas before ras)", cf[0], rf[0]);

    // R7: lone refresh
    clear_log();
    refresh();
    idle();
    if (cf.size() == 1 && rf.size() == 1)
      chk(rf[0] - cf[0] == 6, "R7 cas leads ras", rf[0] - cf[0], 6);
    else chk(0, "R7 refresh edges", cf.size(), 1);

    // R11: scaled frame and clamped setting
    wait_cfg = 4'd7;
    clear_log();
    access(0, 12'h055, 12'h0AA, 0);
    access(1, 12'h066, 12'h0BB, 24'h123456);
    idle();
    if (rf.size() == 2) chk(rf[1] - rf[0] == 32, "R11 ws7 frame", rf[1] - rf[0], 32);
    else chk(0, "R11 ws7 frames", rf.size(), 2);
    wait_cfg = 4'd1;
    clear_log();
    refresh();
    access(0, 12'h001, 12'h002, 0);
    idle();
    if (rf.size() == 2 && rr.size() == 2) begin
      chk(rf[1] - rf[0] == 16, "R11 clamp frame", rf[1] - rf[0], 16);
      chk(rr[0] - rf[0] == 10, "R11 clamp ras width", rr[0] - rf[0], 10);
    end else chk(0, "R11 clamp frames", rf.size(), 2);
    wait_cfg = 4'd15;
    access(0, 12'h7FF, 12'h800, 0);
    idle();
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(negedge clk);
        total++; bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule